// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block is the address-generation stage of a microprogrammed control unit. It owns a 17-bit control address register whose value addresses a control store of 2^17 words. On every rising clock edge the register either steps to the following word or jumps to a branch target. The jump decision comes from an eight-way condition multiplexer that a 3-bit select field of the current microinstruction drives. Its inputs are the two constants and the datapath status flags.

A one-bit source field of the microinstruction picks the branch target. It is either the 17-bit address field carried in the microinstruction, or the instruction opcode padded with zeros to 17 bits. The opcode target lets the microprogram dispatch to the routine of the instruction just fetched. A synchronous reset returns the register to a fixed start address and overrides every other choice. The control store contents and the datapath lie outside this block.

Top module: `usq_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `ctl_addr` becomes `RESET_ADDR` (default 0) on that edge, whatever the select, source and flag inputs are.
- R2: When the selected condition is 0 and `rst` is low, `ctl_addr` becomes its previous value plus one on the edge.
- R3: Incrementing from all ones (17'h1FFFF) wraps `ctl_addr` to 0.
- R4: Select code 0 picks constant 0, so the address never branches. Select code 1 picks constant 1, so the address always branches.
- R5: The select codes for the flags are 2 = carry, 3 = overflow, 4 = zero, 5 = negative, 6 = carry and 7 = zero. The branch is taken exactly when the chosen flag is 1.
- R6: On a taken branch with `src_opcode` = 0, `ctl_addr` becomes `next_field`.
- R7: On a taken branch with `src_opcode` = 1, `ctl_addr` becomes `opcode` zero-extended to 17 bits.
- R8: When the branch is not taken, the values of `next_field`, `opcode` and `src_opcode` have no effect on `ctl_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset to the start address |
| flag_c | input | 1 | Carry status flag |
| flag_v | input | 1 | Overflow status flag |
| flag_z | input | 1 | Zero status flag |
| flag_n | input | 1 | Negative status flag |
| cond_sel | input | 3 | Condition select code |
| src_opcode | input | 1 | Branch target source: 0 address field, 1 opcode |
| next_field | input | 17 | Branch address carried in the microinstruction |
| opcode | input | 7 | Instruction opcode |
| ctl_addr | output | 17 | Control store address |

## Verification
Any fault in this block surfaces on `ctl_addr` at the very next rising edge. A wrong condition index, target source or increment appears there as a jump or a step that should not have happened. Because every later address builds on the previous one, one wrong update also shifts the whole following sequence. Comparing the output against a reference model on every cycle therefore pins a fault to the exact edge that caused it. Walking each select code across both flag values covers every multiplexer input.

// File: rtl/usq_pkg.sv
package usq_pkg;
    localparam int ADDR_W = 17;
    localparam int OP_W   = 7;
    localparam int SEL_W  = 3;

    // Fixed condition indices on the select multiplexer
    typedef enum logic [SEL_W-1:0] {
        COND_NEVER  = 3'd0,
        COND_ALWAYS = 3'd1,
        COND_C0     = 3'd2,
        COND_V      = 3'd3,
        COND_Z0     = 3'd4,
        COND_N      = 3'd5,
        COND_C1     = 3'd6,
        COND_Z1     = 3'd7
    } cond_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } seq_state_t;
endpackage

// File: rtl/usq_cond_select.sv
module usq_cond_select
    import usq_pkg::*;
#(
    parameter int SW = SEL_W
) (
    input  logic [SW-1:0] sel,
    input  logic          fc,
    input  logic          fv,
    input  logic          fz,
    input  logic          fn,
    output logic          hit
);
    localparam int NIN = 1 << SW;
    logic [NIN-1:0] inputs;

    always_comb begin
        inputs = '0;
        inputs[COND_NEVER]  = 1'b0;
        inputs[COND_ALWAYS] = 1'b1;
        inputs[COND_C0]     = fc;
        inputs[COND_V]      = fv;
        inputs[COND_Z0]     = fz;
        inputs[COND_N]      = fn;
        inputs[COND_C1]     = fc;
        inputs[COND_Z1]     = fz;
        hit = inputs[sel];
    end
endmodule

// File: rtl/usq_target_select.sv
module usq_target_select
    import usq_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int OW = OP_W
) (
    input  logic          use_op,
    input  logic [AW-1:0] field,
    input  logic [OW-1:0] op,
    output logic [AW-1:0] target
);
    localparam int PAD = AW - OW;
    logic [AW-1:0] op_ext;

    always_comb begin
        op_ext = {{PAD{1'b0}}, op};
        target = use_op ? op_ext : field;
    end
endmodule

// File: rtl/usq_sequencer.sv
module usq_sequencer
    import usq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flag_c,
    input  logic              flag_v,
    input  logic              flag_z,
    input  logic              flag_n,
    input  logic [SEL_W-1:0]  cond_sel,
    input  logic              src_opcode,
    input  logic [ADDR_W-1:0] next_field,
    input  logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] ctl_addr
);
    seq_state_t        state_d, state_q;
    logic              taken;
    logic [ADDR_W-1:0] target;

    usq_cond_select #(.SW(SEL_W)) u_cond (
        .sel (cond_sel),
        .fc  (flag_c),
        .fv  (flag_v),
        .fz  (flag_z),
        .fn  (flag_n),
        .hit (taken)
    );

    usq_target_select #(.AW(ADDR_W), .OW(OP_W)) u_tgt (
        .use_op (src_opcode),
        .field  (next_field),
        .op     (opcode),
        .target (target)
    );

    always_comb begin
        state_d = state_q;
        if (rst)
            state_d.addr = RESET_ADDR;
        else if (taken)
            state_d.addr = target;
        else
            state_d.addr = state_q.addr + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign ctl_addr = state_q.addr;

    assert_never_R4: assert property (@(posedge clk) disable iff (rst)
        (cond_sel == COND_NEVER) |=> ctl_addr == $past(ctl_addr) + ADDR_W'(1));

    assert_incr_R2: assert property (@(posedge clk) disable iff (rst)
        !taken |=> ctl_addr == $past(ctl_addr) + ADDR_W'(1));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (!taken && ctl_addr == '1) |=> ctl_addr == '0);

    assert_field_R6: assert property (@(posedge clk) disable iff (rst)
        (taken && !src_opcode) |=> ctl_addr == $past(next_field));

    assert_opcode_R7: assert property (@(posedge clk) disable iff (rst)
        (taken && src_opcode) |=> ctl_addr == ADDR_W'($past(opcode)));

    assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
        ((cond_sel == COND_C0 || cond_sel == COND_C1) && !flag_c)
            |=> ctl_addr == $past(ctl_addr) + ADDR_W'(1));
endmodule

// File: tb/usq_sequencer_test.sv
module usq_sequencer_test;
    localparam int AW = 17;
    localparam int OW = 7;
    localparam logic [AW-1:0] START = '0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fc = 0, fv = 0, fz = 0, fn = 0;
    logic [2:0]    sel = 3'd0;
    logic          src = 1'b0;
    logic [AW-1:0] nf = '0;
    logic [OW-1:0] op = '0;
    logic [AW-1:0] addr;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    logic [AW-1:0] model = '0;

    always #4 clk = ~clk;

    usq_sequencer uut (
        .clk(clk), .rst(rst), .flag_c(fc), .flag_v(fv), .flag_z(fz),
        .flag_n(fn), .cond_sel(sel), .src_opcode(src), .next_field(nf),
        .opcode(op), .ctl_addr(addr)
    );

    function automatic bit cond_of(input logic [2:0] s);
        case (s)
            3'd0: return 1'b0;
            3'd1: return 1'b1;
            3'd2, 3'd6: return fc;
            3'd3: return fv;
            3'd5: return fn;
            default: return fz;
        endcase
    endfunction

    // Inputs are already applied (after a falling edge); predict, then
    // wait for the next falling edge and compare.
    task automatic step(input string tag);
        logic [AW-1:0] exp;
        if (rst) exp = START;
        else if (cond_of(sel)) exp = src ? AW'(op) : nf;
        else exp = model + AW'(1);
        @(negedge clk);
        checks++;
        if (addr !== exp) begin
            errors++;
            $display("FAIL %s: ctl_addr=%h expected=%h", tag, addr, exp);
        end
        model = exp;
    endtask

    task automatic drive(input logic r, input logic [2:0] s, input logic so,
                         input logic [AW-1:0] f, input logic [OW-1:0] o);
        rst = r; sel = s; src = so; nf = f; op = o;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: ctl_addr=%h expected=finished", addr);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state with a branch request present
        drive(1, 3'd1, 0, 17'h0ABCD, 7'h11);
        step("R1");
        step("R1");
        // R4/R8: constant 0 never branches; fields ignored
        drive(0, 3'd0, 0, 17'h1F0F0, 7'h7F);
        step("R4");
        drive(0, 3'd0, 1, 17'h00055, 7'h2A);
        step("R8");
        // R6: always-branch to address field
        drive(0, 3'd1, 0, 17'h12345, 7'h00);
        step("R6");
        // R7: always-branch to zero-extended opcode
        drive(0, 3'd1, 1, 17'h1FFFF, 7'h7E);
        step("R7");
        // R3: jump to all ones, then increment wraps
        drive(0, 3'd1, 0, 17'h1FFFF, 7'h00);
        step("R6");
        drive(0, 3'd0, 0, 17'h00000, 7'h00);
        step("R3");
        step("R2");
        // R5: every select code against both values of every flag
        for (int s = 2; s < 8; s++) begin
            for (int v = 0; v < 16; v++) begin
                {fc, fv, fz, fn} = 4'(v);
                drive(0, 3'(s), v[0], AW'(s * 1000 + v), 7'(v * 5));
                step("R5");
            end
        end
        // R1: reset wins over a taken branch mid-run
        drive(1, 3'd1, 1, 17'h00777, 7'h33);
        step("R1");
        // Random traffic: R2, R6, R7, R8 mixed
        for (int i = 0; i < 3000; i++) begin
            {fc, fv, fz, fn} = 4'($urandom);
            drive(($urandom % 64) == 0, 3'($urandom), 1'($urandom),
                  AW'($urandom), OW'($urandom));
            if (rst) step("R1");
            else if (!cond_of(sel)) step("R8");
            else if (src) step("R7");
            else step("R6");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule